// File: doc/BRIEF.md
# Packed float-to-integer converter

This block turns a vector of IEEE-754 single-precision numbers into signed 32-bit integers. Each 32-bit lane is converted on its own. A width select sets how many lanes take part: 4, 8 or 16 lanes, which is 128, 256 or 512 bits. When a lane's value is not a whole number, it is rounded by a 2-bit rounding mode. That mode comes from a global control pin, unless a per-operation override is enabled. A lane whose rounded value does not fit in a signed 32-bit integer raises the invalid flag and returns the indefinite value 0x80000000.

The result is merged into an old destination vector that arrives with each operation. A per-lane write mask can be turned on. When it is on, lanes with a clear mask bit are either zeroed or kept. Lanes above the active width are either zeroed or kept, chosen by a separate pin. The block receives a source vector that is already assembled. It does no memory access, no decode and no broadcast.

Operations arrive on a valid/ready stream and leave on one. The core is a fixed two-stage pipeline. It accepts one operation per cycle while the output side keeps up. When the output is stalled, the whole pipeline freezes. `in_ready` is high exactly when the output register is empty or is being taken in the same cycle. A result stays on `out_dst` and the flag outputs, unchanged, until `out_ready` is seen high. An upstream sender may change or drop its offer only after a cycle in which `in_valid` and `in_ready` were both high.

Top module: `pk_f2i_conv`

## Requirements
- R1: `in_width` selects the active lane count: 2'b00 gives 4 lanes (bits 127:0), 2'b01 gives 8 lanes (bits 255:0), and 2'b10 or 2'b11 gives 16 lanes. Lane i occupies bits 32*i+31 to 32*i.
- R2: An inexact lane is rounded by the mode code: 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero. Subnormal inputs are converted by value.
- R3: The mode used is `in_rc_ovr` when `in_rc_ovr_en` is 1, and `rc_global` otherwise. Both are sampled with the operation.
- R4: A NaN of either sign, an infinity of either sign, or any value whose rounded result lies outside [-2^31, 2^31-1] gives 0x80000000 in that lane and marks the lane invalid.
- R5: A value that rounds to exactly -2^31 is valid and gives 0x80000000 without marking invalid. A value that rounds to +2^31 is invalid.
- R6: A lane marks inexact only when its conversion was inexact and the lane is not invalid.
- R7: `out_invalid` and `out_inexact` are each the OR of that lane mark over all lanes that are active and write-enabled. Other lanes have no effect on the flags.
- R8: Active lanes are all written when `in_mask_en` is 0. When `in_mask_en` is 1, an active lane is written only if its bit in `in_wmask` is 1. A lane with a clear bit becomes zero when `in_zero_en` is 1, and keeps its `in_old` value when `in_zero_en` is 0.
- R9: Lanes above the active width become zero when `in_upper_zero` is 1, and keep their `in_old` value when it is 0.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values.
- R11: An operation accepted at a clock edge shows on the outputs after exactly two rising edges when no stall occurs. Results leave in the order the operations were accepted.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block takes the offered operation at this edge |
| in_src | input | 512 | Source lanes, single precision |
| in_old | input | 512 | Previous destination contents |
| in_width | input | 2 | Active lane count select |
| in_wmask | input | 16 | Per-lane write mask |
| in_mask_en | input | 1 | Apply the write mask |
| in_zero_en | input | 1 | Masked-off lanes become zero instead of kept |
| in_upper_zero | input | 1 | Lanes above the active width become zero instead of kept |
| rc_global | input | 2 | Global rounding mode |
| in_rc_ovr_en | input | 1 | Use the per-operation rounding mode |
| in_rc_ovr | input | 2 | Per-operation rounding mode |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_dst | output | 512 | Merged destination vector |
| out_invalid | output | 1 | Some enabled lane was invalid |
| out_inexact | output | 1 | Some enabled lane was inexact |

## Verification
Each accepted operation is due on the outputs two rising edges after the edge that took it, plus one edge for every cycle the output spends stalled. Stall cycles can only push a result later. Because results can arrive late, the scoreboard does not tie a result to a cycle number. It pairs results with operations by order, and it compares only at a cycle where `out_valid` and `out_ready` are both high. For a set of operations sent with back-pressure switched off, the bench also records the cycle of acceptance and demands that the difference is exactly two cycles.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int LANE_W = 32;
  localparam logic [LANE_W-1:0] INDEF_INT = 32'h8000_0000;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_FLOOR     = 2'b01,
    RM_CEIL      = 2'b10,
    RM_TRUNC     = 2'b11
  } rmode_e;

  // number of active lanes for a width code, limited to what the instance has
  function automatic int unsigned width_lanes(input logic [1:0] sel, input int unsigned max_l);
    int unsigned n;
    case (sel)
      2'b00:   n = 4;
      2'b01:   n = 8;
      default: n = 16;
    endcase
    return (n > max_l) ? max_l : n;
  endfunction

endpackage

// File: rtl/f2i_lane_cvt.sv
module f2i_lane_cvt
  import f2i_pkg::*;
(
  input  logic [31:0] fp_in,
  input  rmode_e      rmode,
  output logic [31:0] int_out,
  output logic        flag_inv,
  output logic        flag_inx
);

  localparam logic [7:0] BIAS_INT = 8'd150;  // exponent at which the significand is an integer
  localparam logic [7:0] EXP_HUGE = 8'd159;  // from here on the magnitude is at least 2^32

  logic        sgn;
  logic [7:0]  ex_raw;
  logic [7:0]  ex_eff;
  logic [23:0] sig;
  logic [7:0]  rsh;
  logic [5:0]  rsh_c;
  logic [87:0] wide;
  logic [23:0] ipart;
  logic        grd;
  logic        stk;
  logic        bump;
  logic        huge;
  logic        frac_path;
  logic        over;
  logic [32:0] mag;

  always_comb begin
    sgn    = fp_in[31];
    ex_raw = fp_in[30:23];
    sig    = {|ex_raw, fp_in[22:0]};
    ex_eff = (ex_raw == 8'd0) ? 8'd1 : ex_raw;

    // right-shift path for values with a fractional part
    frac_path = ex_eff < BIAS_INT;
    rsh       = BIAS_INT - ex_eff;
    rsh_c     = (rsh > 8'd63) ? 6'd63 : rsh[5:0];
    wide      = {sig, 64'd0} >> rsh_c;
    ipart     = wide[87:64];
    grd       = wide[63];
    stk       = |wide[62:0];

    case (rmode)
      RM_NEAR_EVEN: bump = grd & (stk | ipart[0]);
      RM_FLOOR:     bump = (grd | stk) & sgn;
      RM_CEIL:      bump = (grd | stk) & ~sgn;
      default:      bump = 1'b0;
    endcase

    huge = ex_eff >= EXP_HUGE;
    if (frac_path)
      mag = {9'd0, ipart} + {32'd0, bump};
    else
      mag = {9'd0, sig} << (ex_eff - BIAS_INT);

    // negative side reaches one step further than the positive side
    over = sgn ? (mag > 33'h0_8000_0000) : (mag[32] | mag[31]);

    flag_inv = huge | over;
    flag_inx = frac_path & (grd | stk) & ~flag_inv;
    int_out  = flag_inv ? INDEF_INT : (sgn ? (32'd0 - mag[31:0]) : mag[31:0]);
  end

endmodule

// File: rtl/f2i_lane_merge.sv
module f2i_lane_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] conv,
  input  logic [W-1:0] old,
  input  logic         active,
  input  logic         wr_en,
  input  logic         zero_en,
  input  logic         upper_zero,
  output logic [W-1:0] val
);

  always_comb begin
    if (!active)
      val = upper_zero ? '0 : old;
    else if (wr_en)
      val = conv;
    else
      val = zero_en ? '0 : old;
  end

endmodule

// File: rtl/pk_f2i_conv.sv
module pk_f2i_conv
  import f2i_pkg::*;
#(
  parameter int MAX_LANES = 16,
  localparam int VEC_W = MAX_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC_W-1:0]   in_src,
  input  logic [VEC_W-1:0]   in_old,
  input  logic [1:0]         in_width,
  input  logic [MAX_LANES-1:0] in_wmask,
  input  logic               in_mask_en,
  input  logic               in_zero_en,
  input  logic               in_upper_zero,
  input  logic [1:0]         rc_global,
  input  logic               in_rc_ovr_en,
  input  logic [1:0]         in_rc_ovr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_dst,
  output logic               out_invalid,
  output logic               out_inexact
);

  // pipeline moves as one unit; it freezes only when the output is held
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  rmode_e      rm_eff;
  int unsigned n_act;
  assign rm_eff = rmode_e'(in_rc_ovr_en ? in_rc_ovr : rc_global);
  assign n_act  = width_lanes(in_width, MAX_LANES);

  // stage 0: per-lane conversion and lane classification
  logic [VEC_W-1:0]     c_res;
  logic [MAX_LANES-1:0] c_inv;
  logic [MAX_LANES-1:0] c_inx;
  logic [MAX_LANES-1:0] c_act;
  logic [MAX_LANES-1:0] c_we;

  for (genvar li = 0; li < MAX_LANES; li++) begin : g_cvt
    f2i_lane_cvt u_cvt (
      .fp_in   (in_src[li*LANE_W +: LANE_W]),
      .rmode   (rm_eff),
      .int_out (c_res[li*LANE_W +: LANE_W]),
      .flag_inv(c_inv[li]),
      .flag_inx(c_inx[li])
    );
    assign c_act[li] = li < n_act;
    assign c_we[li]  = !in_mask_en || in_wmask[li];
  end

  // stage 1 registers
  logic                 s1_valid;
  logic [VEC_W-1:0]     s1_res;
  logic [VEC_W-1:0]     s1_old;
  logic [MAX_LANES-1:0] s1_inv;
  logic [MAX_LANES-1:0] s1_inx;
  logic [MAX_LANES-1:0] s1_act;
  logic [MAX_LANES-1:0] s1_we;
  logic                 s1_zero;
  logic                 s1_upz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_res   <= '0;
      s1_old   <= '0;
      s1_inv   <= '0;
      s1_inx   <= '0;
      s1_act   <= '0;
      s1_we    <= '0;
      s1_zero  <= 1'b0;
      s1_upz   <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_res   <= c_res;
      s1_old   <= in_old;
      s1_inv   <= c_inv;
      s1_inx   <= c_inx;
      s1_act   <= c_act;
      s1_we    <= c_we;
      s1_zero  <= in_zero_en;
      s1_upz   <= in_upper_zero;
    end
  end

  // stage 1 -> output: lane merge and flag reduction
  logic [VEC_W-1:0]     m_dst;
  logic [MAX_LANES-1:0] flag_en;

  for (genvar lj = 0; lj < MAX_LANES; lj++) begin : g_mrg
    f2i_lane_merge #(.W(LANE_W)) u_mrg (
      .conv      (s1_res[lj*LANE_W +: LANE_W]),
      .old       (s1_old[lj*LANE_W +: LANE_W]),
      .active    (s1_act[lj]),
      .wr_en     (s1_we[lj]),
      .zero_en   (s1_zero),
      .upper_zero(s1_upz),
      .val       (m_dst[lj*LANE_W +: LANE_W])
    );
  end

  assign flag_en = s1_act & s1_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_dst     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else if (advance) begin
      out_valid   <= s1_valid;
      out_dst     <= m_dst;
      out_invalid <= |(s1_inv & flag_en);
      out_inexact <= |(s1_inx & flag_en);
    end
  end

endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int LANES = 16,
  localparam int VW = LANES * 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VW-1:0]    out_dst,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             s1_valid,
  input logic [VW-1:0]    s1_res,
  input logic [LANES-1:0] s1_inv,
  input logic [LANES-1:0] s1_inx
);

  // R10: a stalled result does not move
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst)
                                && $stable(out_invalid) && $stable(out_inexact));

  // R11: an accepted operation is on the output no later than two edges on,
  // and a stall in between keeps out_valid high
  p_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ##1 out_valid);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // R4: an invalid lane carries the indefinite integer
    p_indef_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && s1_inv[k] |-> s1_res[k*32 +: 32] == 32'h8000_0000);
    // R6: inexact is never reported together with invalid
    p_prec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> !(s1_inv[k] && s1_inx[k]));
  end

endmodule

bind pk_f2i_conv f2i_conv_chk #(.LANES(MAX_LANES)) u_f2i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_dst    (out_dst),
  .out_invalid(out_invalid),
  .out_inexact(out_inexact),
  .s1_valid   (s1_valid),
  .s1_res     (s1_res),
  .s1_inv     (s1_inv),
  .s1_inx     (s1_inx)
);

// File: tb/pk_f2i_conv_tb_top.sv
module pk_f2i_conv_tb_top;

  localparam int NL = 16;
  localparam int VW = NL * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_src = '0;
  logic [VW-1:0] in_old = '0;
  logic [1:0]    in_width = 2'b10;
  logic [NL-1:0] in_wmask = '0;
  logic          in_mask_en = 1'b0;
  logic          in_zero_en = 1'b0;
  logic          in_upper_zero = 1'b0;
  logic [1:0]    rc_global = 2'b00;
  logic          in_rc_ovr_en = 1'b0;
  logic [1:0]    in_rc_ovr = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_dst;
  logic          out_invalid;
  logic          out_inexact;

  always #4 clk = ~clk;  // 125 MHz

  pk_f2i_conv #(.MAX_LANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_old(in_old), .in_width(in_width), .in_wmask(in_wmask),
    .in_mask_en(in_mask_en), .in_zero_en(in_zero_en), .in_upper_zero(in_upper_zero),
    .rc_global(rc_global), .in_rc_ovr_en(in_rc_ovr_en), .in_rc_ovr(in_rc_ovr),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  typedef struct packed {
    logic [VW-1:0] dst;
    logic          inv;
    logic          inx;
    logic [31:0]   cyc;
    logic          lat;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  logic [31:0] cyc = 0;
  bit    bp_on = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference conversion: {inv, inx, value}
  function automatic logic [33:0] ref_cvt(input logic [31:0] f, input logic [1:0] rm);
    bit      s;
    int      e;
    int      sh;
    longint  sig;
    longint  q;
    longint  r;
    longint  half;
    bit      bad;
    bit      up;
    logic [31:0] v;
    s = f[31];
    e = int'(f[30:23]);
    bad = (e == 255);
    sig = (e == 0) ? longint'(f[22:0]) : longint'(f[22:0]) + 64'd8388608;
    if (e == 0) e = 1;
    q = 0; r = 0; half = 1; up = 0;
    if (!bad) begin
      if (e >= 150) begin
        if (e - 150 > 8) bad = 1;
        else q = sig << (e - 150);
      end else begin
        sh = 150 - e;
        if (sh > 40) begin
          q = 0; r = sig; half = longint'(1) << 40;
        end else begin
          q = sig >> sh;
          r = sig - (q << sh);
          half = longint'(1) << (sh - 1);
        end
        case (rm)
          2'b00: up = (r > half) || (r == half && q[0]);
          2'b01: up = (r != 0) && s;
          2'b10: up = (r != 0) && !s;
          default: up = 0;
        endcase
        if (up) q = q + 1;
      end
      if (s ? (q > 64'h8000_0000) : (q >= 64'h8000_0000)) bad = 1;
    end
    v = bad ? 32'h8000_0000 : (s ? 32'(-q) : 32'(q));
    return {bad, (!bad && r != 0), v};
  endfunction

  task automatic send(input logic [VW-1:0] src, input logic [VW-1:0] old,
                      input logic [1:0] wsel, input logic [NL-1:0] wm,
                      input logic men, input logic zen, input logic upz,
                      input logic [1:0] rg, input logic oen, input logic [1:0] ro,
                      input string tag, input bit lat);
    exp_t e;
    int   cnt;
    logic [1:0] rm;
    logic [33:0] c;
    cnt = (wsel == 2'b00) ? 4 : (wsel == 2'b01) ? 8 : 16;
    rm  = oen ? ro : rg;
    e.inv = 0; e.inx = 0; e.lat = lat;
    for (int i = 0; i < NL; i++) begin
      c = ref_cvt(src[i*32 +: 32], rm);
      if (i >= cnt)
        e.dst[i*32 +: 32] = upz ? 32'd0 : old[i*32 +: 32];
      else if (!men || wm[i]) begin
        e.dst[i*32 +: 32] = c[31:0];
        e.inv = e.inv | c[33];
        e.inx = e.inx | c[32];
      end else
        e.dst[i*32 +: 32] = zen ? 32'd0 : old[i*32 +: 32];
    end
    @(negedge clk); #2;
    in_valid = 1; in_src = src; in_old = old; in_width = wsel; in_wmask = wm;
    in_mask_en = men; in_zero_en = zen; in_upper_zero = upz;
    rc_global = rg; in_rc_ovr_en = oen; in_rc_ovr = ro;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    e.cyc = cyc;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R11 unexpected result got %h exp none", out_dst);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_chk++;
          if (out_dst !== e.dst) begin
            n_bad++;
            $display("FAIL %s dst got %h exp %h", t, out_dst, e.dst);
          end
          n_chk++;
          if (out_invalid !== e.inv || out_inexact !== e.inx) begin
            n_bad++;
            $display("FAIL %s flags inv/inx got %b%b exp %b%b", t, out_invalid, out_inexact, e.inv, e.inx);
          end
          if (e.lat) begin
            n_chk++;
            if (cyc - e.cyc != 2) begin
              n_bad++;
              $display("FAIL R11 latency got %0d exp 2", cyc - e.cyc);
            end
          end
        end
      end
    end
  end

  function automatic logic [31:0] rand_f();
    int k;
    logic [7:0] ex;
    k = $urandom % 16;
    case (k)
      0: return {1'($urandom), 8'hFF, 1'b1, 22'($urandom)};
      1: return {1'($urandom), 8'hFF, 23'd0};
      2: return {1'($urandom), 8'h00, 23'($urandom)};
      3: return {1'($urandom), 8'(157 + $urandom % 3), 23'($urandom % 4)};
      default: begin
        ex = 8'(120 + $urandom % 42);
        return {1'($urandom), ex, 23'($urandom)};
      end
    endcase
  endfunction

  logic [31:0] rv [16] = '{32'h3FC00000, 32'h40200000, 32'hBFC00000, 32'hC0200000,
                           32'h3F000000, 32'hBF000000, 32'h40600000, 32'h00000001,
                           32'h4EFFFFFF, 32'h80000000, 32'h3F400000, 32'hBF400000,
                           32'h42C80000, 32'hC2C90000, 32'h80000001, 32'h3E800000};
  logic [31:0] sp [16] = '{32'h7FC00000, 32'hFFC00000, 32'h7F800000, 32'hFF800000,
                           32'h4F000000, 32'hCF000000, 32'hCF000001, 32'h4F32D05E,
                           32'h4EFFFFFF, 32'hCEFFFFFF, 32'h3F800000, 32'hBF800000,
                           32'h00000000, 32'h7F7FFFFF, 32'hFF7FFFFF, 32'h40000000};

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got %0d pending exp 0", exp_q.size());
    finish_run();
  end

  initial begin
    logic [VW-1:0] v;
    logic [VW-1:0] o;
    logic [VW-1:0] sv;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    n_chk++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R12 out_valid got %b exp 0", out_valid); end
    n_chk++;
    if (in_ready !== 1'b1) begin n_bad++; $display("FAIL R12 in_ready got %b exp 1", in_ready); end
    rst_n = 1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NL; i++) begin
      v[i*32 +: 32]  = rv[i];
      sv[i*32 +: 32] = sp[i];
      o[i*32 +: 32]  = 32'hA5A50000 | 32'(i);
    end

    // R2 all modes from the global pin
    for (int m = 0; m < 4; m++)
      send(v, o, 2'b10, '0, 0, 0, 0, 2'(m), 0, 2'b00, "R2", 0);
    // R3 override beats the global mode
    for (int m = 0; m < 4; m++)
      send(v, o, 2'b10, '0, 0, 0, 0, 2'(3 - m), 1, 2'(m), "R3", 0);
    // R4 R5 specials and range edges
    send(sv, o, 2'b10, '0, 0, 0, 0, 2'b00, 0, 2'b00, "R4_R5", 0);
    send(sv, o, 2'b10, '0, 0, 0, 0, 2'b10, 0, 2'b00, "R4_R5", 0);
    // R5 lone -2^31: no invalid
    send({480'd0, 32'hCF000000}, o, 2'b00, '0, 0, 0, 1, 2'b00, 0, 2'b00, "R5", 0);
    // R6 NaN lane with exact lanes: invalid only, no inexact
    send({384'd0, 32'h40000000, 32'h3F800000, 32'h00000000, 32'h7FC00000}, o,
         2'b00, '0, 0, 0, 1, 2'b00, 0, 2'b00, "R6", 0);
    // R7 NaN and 0.5 in masked-off lanes leave the flags clear
    send({384'd0, 32'h40000000, 32'h3F000000, 32'h3F800000, 32'h7FC00000}, o,
         2'b00, 16'h0002, 1, 0, 1, 2'b00, 0, 2'b00, "R7", 0);
    // R7 invalid lane above the active width does not count
    send({sv[VW-1:128], 96'd0, 32'h3F800000}, o, 2'b00, '0, 0, 0, 0, 2'b00, 0, 2'b00, "R7", 0);
    // R8 mask with zeroing and with keeping
    send(v, o, 2'b10, 16'hA5C3, 1, 1, 0, 2'b00, 0, 2'b00, "R8", 0);
    send(v, o, 2'b10, 16'hA5C3, 1, 0, 0, 2'b00, 0, 2'b00, "R8", 0);
    send(v, o, 2'b10, 16'h0000, 1, 0, 0, 2'b00, 0, 2'b00, "R8", 0);
    // R1 R9 widths with both upper policies
    for (int w = 0; w < 4; w++) begin
      send(v, o, 2'(w), 16'hFFFF, 1, 0, 1, 2'b00, 0, 2'b00, "R1_R9", 0);
      send(v, o, 2'(w), 16'h5555, 1, 1, 0, 2'b11, 0, 2'b00, "R1_R9", 0);
    end
    // R11 latency without back-pressure
    for (int k = 0; k < 4; k++)
      send(sv, o, 2'b01, '0, 0, 0, 0, 2'b01, 0, 2'b00, "R11", 1);

    // R10 random traffic under back-pressure
    bp_on = 1;
    for (int n = 0; n < 300; n++) begin
      logic [VW-1:0] rs;
      logic [VW-1:0] ro;
      for (int i = 0; i < NL; i++) begin
        rs[i*32 +: 32] = rand_f();
        ro[i*32 +: 32] = $urandom;
      end
      send(rs, ro, 2'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), 2'($urandom), "R10", 0);
    end
    bp_on = 0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule